// File: doc/BRIEF.md
# Latency-Driven Issue Interlock

This block sits beside the decode stage of a single-issue, in-order pipeline and decides, every cycle, whether the instruction waiting in decode may issue or has to wait. It remembers which registers have results still in flight, which kind of operation is producing each one (integer op, FP ALU op or load), and how many cycles remain. It compares the decode instruction's two source registers and its own kind against that record. The required spacing depends on both the producing kind and the consuming kind. For example, a store that reads an FP ALU result waits less than an FP ALU op that reads the same result.

When a dependence is still too close, the block raises `stall`. The surrounding pipeline keeps the decode instruction in place and inserts a bubble. Otherwise the block raises `issue`, and if the instruction writes a register, the block starts that register's countdown. Countdowns keep running during stalls. The integer file and the FP file are tracked separately, and integer register 0 is never tracked. The block contains no datapath, forwarding, branch or memory logic.

Top module: `lat_interlock`

## Requirements
- R1: A synchronous active-high `rst` clears every pending result. In the first cycle after reset, and afterwards until a producer issues, no decode instruction stalls.
- R2: Instruction kind encoding on `dec_kind` is 0 integer op, 1 FP ALU op, 2 load, 3 store. An FP ALU op that reads the result of the FP ALU op issued just before it stalls for exactly 3 cycles.
- R3: A store (kind 3) that reads the result of the FP ALU op issued just before it stalls for exactly 2 cycles.
- R4: An FP ALU op that reads the result of the load (kind 2) issued just before it stalls for exactly 1 cycle.
- R5: A store that reads the result of the load issued just before it does not stall.
- R6: Every producer/consumer pair other than FP ALU→FP ALU, FP ALU→store and load→FP ALU needs no spacing. This includes integer op → integer op, so such pairs never stall.
- R7: Integer register 0 (file select 0, index 0) is never tracked. A load that writes it causes no stall in a following FP ALU op that reads it, while the same sequence on integer register 7 stalls for 1 cycle.
- R8: The FP file (file select 1) and the integer file (file select 0) are independent. A pending FP register n does not stall a reader of integer register n.
- R9: `issue` is high exactly when `dec_valid` is high and no source hazard exists. `stall` is never high without `dec_valid`, and an unbroken run of stall cycles never exceeds 3.
- R10: Countdowns advance in every cycle, including stall and bubble cycles. An FP ALU op followed by an unrelated instruction and then by a dependent FP ALU op stalls for 2 cycles. A load → FP ALU op → store chain stalls 1 cycle and then 2 cycles.
- R11: The write-enable of a store is ignored. A store with `dec_wr_en` set does not make a later reader of the named register stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_kind | input | 2 | Instruction kind: 0 int, 1 FP ALU, 2 load, 3 store |
| dec_sa_used | input | 1 | First source operand present |
| dec_sa_fp | input | 1 | First source file: 1 FP, 0 integer |
| dec_sa_idx | input | 5 | First source register index |
| dec_sb_used | input | 1 | Second source operand present |
| dec_sb_fp | input | 1 | Second source file: 1 FP, 0 integer |
| dec_sb_idx | input | 5 | Second source register index |
| dec_wr_en | input | 1 | Instruction writes a destination |
| dec_wr_fp | input | 1 | Destination file: 1 FP, 0 integer |
| dec_wr_idx | input | 5 | Destination register index |
| stall | output | 1 | Hold decode, issue a bubble |
| issue | output | 1 | Decode instruction issues this cycle |

## Verification
The hardest situation to reach is a consumer whose two sources sit at different points in their countdowns, with a second producer having overwritten a register while an older result to it was still pending. Uniform random stimulus across 32 registers almost never produces this. The random phase therefore confines register indices to 0..3 and mixes all four kinds, which makes back-to-back and skip-one dependences and overwrites frequent. Stalled instructions are held exactly as a pipeline would hold them. A bench model built on issue timestamps predicts every cycle.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int MAXLAT = 3;
    localparam int CNTW   = $clog2(MAXLAT + 1);

    typedef enum logic [1:0] {
        K_INT   = 2'd0,
        K_FPALU = 2'd1,
        K_LOAD  = 2'd2,
        K_STORE = 2'd3
    } kind_e;

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        kind_e           cls;
    } track_t;

    // cycles that must separate a producer of kind p from a consumer of kind c
    function automatic logic [CNTW-1:0] pair_lat(kind_e p, kind_e c);
        logic [CNTW-1:0] r;
        r = '0;
        if (p == K_FPALU && c == K_FPALU) r = CNTW'(3);
        if (p == K_FPALU && c == K_STORE) r = CNTW'(2);
        if (p == K_LOAD  && c == K_FPALU) r = CNTW'(1);
        return r;
    endfunction

    // largest spacing any consumer can need from producer kind p
    function automatic logic [CNTW-1:0] max_lat(kind_e p);
        logic [CNTW-1:0] r;
        case (p)
            K_FPALU: r = CNTW'(3);
            K_LOAD:  r = CNTW'(1);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ilk_entry.sv
module ilk_entry
    import ilk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ld,
    input  kind_e  ld_cls,
    output track_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.cnt <= '0;
            q.cls <= K_INT;
        end else if (ld) begin
            q.cnt <= max_lat(ld_cls);
            q.cls <= ld_cls;
        end else if (q.cnt != '0) begin
            q.cnt <= q.cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ilk_bank.sv
module ilk_bank
    import ilk_pkg::*;
#(
    parameter int NREGS     = 32,
    parameter bit SKIP_ZERO = 1'b0,
    localparam int IDXW     = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  kind_e           wr_cls,
    input  logic [IDXW-1:0] rd_idx_a,
    input  logic [IDXW-1:0] rd_idx_b,
    output track_t          rd_a,
    output track_t          rd_b
);
    track_t trk [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (SKIP_ZERO && i == 0) begin : g_hard
            assign trk[i] = '{cnt: '0, cls: K_INT};
        end else begin : g_trk
            ilk_entry u_entry (
                .clk    (clk),
                .rst    (rst),
                .ld     (wr_en && wr_idx == IDXW'(i)),
                .ld_cls (wr_cls),
                .q      (trk[i])
            );
        end
    end

    assign rd_a = trk[rd_idx_a];
    assign rd_b = trk[rd_idx_b];
endmodule

// File: rtl/ilk_src_check.sv
module ilk_src_check
    import ilk_pkg::*;
(
    input  logic   used,
    input  logic   fp,
    input  track_t trk_int,
    input  track_t trk_fp,
    input  kind_e  cons,
    output logic   hit
);
    track_t sel;
    logic [CNTW-1:0] slack;

    always_comb begin
        sel   = fp ? trk_fp : trk_int;
        // remaining count above this threshold means the gap is still too short
        slack = max_lat(sel.cls) - pair_lat(sel.cls, cons);
        hit   = used && (sel.cnt > slack);
    end
endmodule

// File: rtl/lat_interlock.sv
module lat_interlock
    import ilk_pkg::*;
#(
    parameter int NREGS   = 32,
    localparam int IDXW   = $clog2(NREGS),
    localparam int NSRC   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dec_valid,
    input  logic [1:0]      dec_kind,
    input  logic            dec_sa_used,
    input  logic            dec_sa_fp,
    input  logic [IDXW-1:0] dec_sa_idx,
    input  logic            dec_sb_used,
    input  logic            dec_sb_fp,
    input  logic [IDXW-1:0] dec_sb_idx,
    input  logic            dec_wr_en,
    input  logic            dec_wr_fp,
    input  logic [IDXW-1:0] dec_wr_idx,
    output logic            stall,
    output logic            issue
);
    kind_e  kind;
    track_t int_rd [NSRC];
    track_t fp_rd  [NSRC];
    logic   s_used [NSRC];
    logic   s_fp   [NSRC];
    logic [NSRC-1:0] hits;
    logic   writes;

    assign kind      = kind_e'(dec_kind);
    assign s_used[0] = dec_sa_used;
    assign s_used[1] = dec_sb_used;
    assign s_fp[0]   = dec_sa_fp;
    assign s_fp[1]   = dec_sb_fp;

    // stores name no destination; their write-enable is disregarded
    assign writes = issue && dec_wr_en && (kind != K_STORE);

    ilk_bank #(.NREGS(NREGS), .SKIP_ZERO(1'b1)) u_int_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (writes && !dec_wr_fp),
        .wr_idx   (dec_wr_idx),
        .wr_cls   (kind),
        .rd_idx_a (dec_sa_idx),
        .rd_idx_b (dec_sb_idx),
        .rd_a     (int_rd[0]),
        .rd_b     (int_rd[1])
    );

    ilk_bank #(.NREGS(NREGS), .SKIP_ZERO(1'b0)) u_fp_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (writes && dec_wr_fp),
        .wr_idx   (dec_wr_idx),
        .wr_cls   (kind),
        .rd_idx_a (dec_sa_idx),
        .rd_idx_b (dec_sb_idx),
        .rd_a     (fp_rd[0]),
        .rd_b     (fp_rd[1])
    );

    for (genvar j = 0; j < NSRC; j++) begin : g_src
        ilk_src_check u_chk (
            .used    (s_used[j]),
            .fp      (s_fp[j]),
            .trk_int (int_rd[j]),
            .trk_fp  (fp_rd[j]),
            .cons    (kind),
            .hit     (hits[j])
        );
    end

    assign stall = dec_valid && (|hits);
    assign issue = dec_valid && !(|hits);
endmodule

// File: rtl/lat_interlock_chk.sv
module lat_interlock_chk
    import ilk_pkg::*;
#(
    parameter int IDXW = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            dec_valid,
    input logic [1:0]      dec_kind,
    input logic            dec_sa_used,
    input logic            dec_sa_fp,
    input logic [IDXW-1:0] dec_sa_idx,
    input logic            dec_sb_used,
    input logic            dec_sb_fp,
    input logic [IDXW-1:0] dec_sb_idx,
    input logic            dec_wr_en,
    input logic            dec_wr_fp,
    input logic [IDXW-1:0] dec_wr_idx,
    input logic            stall,
    input logic            issue
);
    logic [3:0] run;

    always_ff @(posedge clk) begin
        if (rst)             run <= '0;
        else if (!stall)     run <= '0;
        else if (run != 4'hF) run <= run + 1'b1;
    end

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !stall);

    a_r2_fp_chain_stalls: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(issue && dec_kind == 2'd1 && dec_wr_en && dec_wr_fp)
         && dec_valid && dec_kind == 2'd1 && dec_sa_used && dec_sa_fp
         && dec_sa_idx == $past(dec_wr_idx)) |-> stall);

    a_r5_load_store_free: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(issue && dec_kind == 2'd2 && dec_wr_en && dec_wr_fp)
         && dec_valid && dec_kind == 2'd3 && dec_sa_used && dec_sa_fp
         && dec_sa_idx == $past(dec_wr_idx) && !dec_sb_used) |-> !stall);

    a_r7_int_zero_free: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_kind == 2'd0
         && (!dec_sa_used || (!dec_sa_fp && dec_sa_idx == '0))
         && (!dec_sb_used || (!dec_sb_fp && dec_sb_idx == '0))) |-> !stall);

    a_r9_idle_no_stall: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!stall && !issue));

    a_r9_stall_bounded: assert property (@(posedge clk) disable iff (rst)
        run <= 4'(MAXLAT));

    a_r9_valid_resolves: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (stall ^ issue));
endmodule

bind lat_interlock lat_interlock_chk #(.IDXW(IDXW)) u_lat_chk (
    .clk         (clk),
    .rst         (rst),
    .dec_valid   (dec_valid),
    .dec_kind    (dec_kind),
    .dec_sa_used (dec_sa_used),
    .dec_sa_fp   (dec_sa_fp),
    .dec_sa_idx  (dec_sa_idx),
    .dec_sb_used (dec_sb_used),
    .dec_sb_fp   (dec_sb_fp),
    .dec_sb_idx  (dec_sb_idx),
    .dec_wr_en   (dec_wr_en),
    .dec_wr_fp   (dec_wr_fp),
    .dec_wr_idx  (dec_wr_idx),
    .stall       (stall),
    .issue       (issue)
);

// File: tb/lat_interlock_tb.sv
module lat_interlock_tb;

    typedef struct {
        bit v; int k;
        bit au; bit af; int ai;
        bit bu; bit bf; int bi;
        bit we; bit wf; int wi;
    } ins_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_valid = 1'b0;
    logic [1:0] dec_kind = '0;
    logic       dec_sa_used = 1'b0, dec_sa_fp = 1'b0;
    logic [4:0] dec_sa_idx = '0;
    logic       dec_sb_used = 1'b0, dec_sb_fp = 1'b0;
    logic [4:0] dec_sb_idx = '0;
    logic       dec_wr_en = 1'b0, dec_wr_fp = 1'b0;
    logic [4:0] dec_wr_idx = '0;
    logic       stall, issue;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rec_cyc  [2][32];
    int rec_kind [2][32];
    bit rec_v    [2][32];

    always #2 clk = ~clk;

    lat_interlock u_dut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .dec_sa_used(dec_sa_used), .dec_sa_fp(dec_sa_fp), .dec_sa_idx(dec_sa_idx),
        .dec_sb_used(dec_sb_used), .dec_sb_fp(dec_sb_fp), .dec_sb_idx(dec_sb_idx),
        .dec_wr_en(dec_wr_en), .dec_wr_fp(dec_wr_fp), .dec_wr_idx(dec_wr_idx),
        .stall(stall), .issue(issue)
    );

    function automatic int lat(int p, int c);
        if (p == 1 && c == 1) return 3;
        if (p == 1 && c == 3) return 2;
        if (p == 2 && c == 1) return 1;
        return 0;
    endfunction

    function automatic bit src_haz(bit u, bit f, int i, int k);
        if (!u) return 0;
        if (!f && i == 0) return 0;
        if (!rec_v[f][i]) return 0;
        return (cyc - rec_cyc[f][i]) <= lat(rec_kind[f][i], k);
    endfunction

    function automatic ins_t mk(int k, bit au, bit af, int ai, bit bu, bit bf, int bi,
                                bit we, bit wf, int wi);
        ins_t r;
        r.v = 1; r.k = k; r.au = au; r.af = af; r.ai = ai;
        r.bu = bu; r.bf = bf; r.bi = bi; r.we = we; r.wf = wf; r.wi = wi;
        return r;
    endfunction

    function automatic ins_t fpop(int d, int a, int b);
        return mk(1, 1, 1, a, 1, 1, b, 1, 1, d);
    endfunction
    function automatic ins_t ldf(int d, int base);
        return mk(2, 1, 0, base, 0, 0, 0, 1, 1, d);
    endfunction
    function automatic ins_t stf(int data, int base);
        return mk(3, 1, 1, data, 1, 0, base, 0, 0, 0);
    endfunction
    function automatic ins_t iop(int d, int a, int b);
        return mk(0, 1, 0, a, 1, 0, b, 1, 0, d);
    endfunction

    task automatic clear_model();
        for (int f = 0; f < 2; f++)
            for (int i = 0; i < 32; i++) rec_v[f][i] = 0;
    endtask

    task automatic drive(input ins_t x, input string tag, output bit st);
        bit exp;
        @(negedge clk);
        dec_valid = x.v; dec_kind = 2'(x.k);
        dec_sa_used = x.au; dec_sa_fp = x.af; dec_sa_idx = 5'(x.ai);
        dec_sb_used = x.bu; dec_sb_fp = x.bf; dec_sb_idx = 5'(x.bi);
        dec_wr_en = x.we; dec_wr_fp = x.wf; dec_wr_idx = 5'(x.wi);
        #1;
        exp = x.v && (src_haz(x.au, x.af, x.ai, x.k) || src_haz(x.bu, x.bf, x.bi, x.k));
        checks++;
        if (stall !== exp || issue !== (x.v && !exp)) begin
            fails++;
            $display("FAIL %s cyc %0d: stall=%b issue=%b expected stall=%b issue=%b",
                     tag, cyc, stall, issue, exp, x.v && !exp);
        end
        st = exp;
        if (x.v && !exp && x.we && x.k != 3 && !(!x.wf && x.wi == 0)) begin
            rec_v[x.wf][x.wi]    = 1;
            rec_cyc[x.wf][x.wi]  = cyc;
            rec_kind[x.wf][x.wi] = x.k;
        end
        @(posedge clk);
        cyc++;
    endtask

    task automatic run_ins(input ins_t x, input string tag, output int n);
        bit st;
        n = 0;
        do begin
            drive(x, tag, st);
            if (st) n++;
        end while (st && n < 8);
    endtask

    task automatic expect_stalls(input ins_t x, input string tag, input int want);
        int n;
        run_ins(x, tag, n);
        checks++;
        if (n != want) begin
            fails++;
            $display("FAIL %s: stall cycles=%0d expected=%0d", tag, n, want);
        end
    endtask

    task automatic idle(input int n);
        ins_t z;
        bit st;
        z = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        z.v = 0;
        for (int i = 0; i < n; i++) drive(z, "idle", st);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; dec_valid = 1'b0;
        @(posedge clk); cyc++;
        @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        bit st;
        ins_t x;
        ins_t z;
        void'($urandom(32'd1234));
        clear_model();
        repeat (2) @(posedge clk);
        do_reset();

        // R1: nothing pending after reset
        expect_stalls(fpop(1, 2, 3), "R1 fresh", 0);
        idle(4);
        expect_stalls(fpop(24, 2, 3), "R1 setup", 0);
        do_reset();
        expect_stalls(fpop(25, 24, 24), "R1 reset clears pending", 0);
        idle(4);

        // R2
        expect_stalls(fpop(4, 0, 2), "R2 producer", 0);
        expect_stalls(fpop(6, 4, 2), "R2 fp->fp", 3);
        idle(4);
        // R3
        expect_stalls(fpop(8, 0, 2), "R3 producer", 0);
        expect_stalls(stf(8, 1), "R3 fp->store", 2);
        idle(4);
        // R4
        expect_stalls(ldf(10, 1), "R4 load", 0);
        expect_stalls(fpop(12, 10, 2), "R4 load->fp", 1);
        idle(4);
        // R5
        expect_stalls(ldf(14, 1), "R5 load", 0);
        expect_stalls(stf(14, 1), "R5 load->store", 0);
        idle(4);
        // R6
        expect_stalls(iop(3, 4, 5), "R6 int", 0);
        expect_stalls(iop(6, 3, 3), "R6 int->int", 0);
        expect_stalls(ldf(15, 6), "R6 int->load addr", 0);
        expect_stalls(fpop(17, 30, 31), "R6 fp writes", 0);
        expect_stalls(iop(7, 6, 6), "R6 unrelated int", 0);
        idle(4);
        // R7: load to integer reg 0 vs reg 7
        expect_stalls(mk(2, 1, 0, 1, 0, 0, 0, 1, 0, 0), "R7 load r0", 0);
        expect_stalls(mk(1, 1, 0, 0, 0, 0, 0, 1, 1, 18), "R7 read r0", 0);
        idle(4);
        expect_stalls(mk(2, 1, 0, 1, 0, 0, 0, 1, 0, 7), "R7 load r7", 0);
        expect_stalls(mk(1, 1, 0, 7, 0, 0, 0, 1, 1, 18), "R7 read r7", 1);
        idle(4);
        // R8: fp reg 9 pending, integer reg 9 read
        expect_stalls(fpop(9, 0, 2), "R8 producer", 0);
        expect_stalls(mk(1, 1, 0, 9, 0, 0, 0, 1, 1, 19), "R8 files independent", 0);
        idle(4);
        // R9: invalid slot never stalls or issues
        expect_stalls(fpop(22, 0, 2), "R9 producer", 0);
        z = fpop(23, 22, 22);
        z.v = 0;
        drive(z, "R9 invalid no stall", st);
        idle(4);
        // R10: countdown runs through gaps and stalls
        expect_stalls(fpop(16, 0, 2), "R10 producer", 0);
        expect_stalls(iop(5, 4, 4), "R10 filler", 0);
        expect_stalls(fpop(18, 16, 2), "R10 one gap", 2);
        idle(4);
        expect_stalls(ldf(0, 1), "R10 chain load", 0);
        expect_stalls(fpop(4, 0, 2), "R10 chain add", 1);
        expect_stalls(stf(4, 1), "R10 chain store", 2);
        idle(4);
        // R11: store write-enable ignored
        x = stf(2, 1);
        x.we = 1; x.wf = 1; x.wi = 20;
        expect_stalls(x, "R11 store with wr_en", 0);
        expect_stalls(fpop(21, 20, 20), "R11 no pending from store", 0);
        idle(4);

        // random phase: small register window, held while stalled (R2-R11)
        for (int it = 0; it < 3000; it++) begin
            x = mk(int'($urandom_range(0, 3)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
            x.v = ($urandom_range(0, 9) != 0);
            run_ins(x, "R9 random", n);
            if (it % 700 == 699) do_reset();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule